// File: doc/BRIEF.md
# ADC Conversion Request Sequencer

This block decides when a shared two-channel converter runs and on which input. It drives a channel select (supply voltage or load current) and a one-cycle start strobe to the converter, waits for its done pulse, and captures the returned 12-bit sample. Requests come from a small command register written by the bus interface, or from an external convert pin. Each channel can run free, restarting as soon as a pass ends, or run a single time, with the request bit clearing itself when the pass is issued.

A pass that covers both channels converts voltage first and current second. Both readback registers change on the same clock edge once the pass ends. The block also gives the bus interface a read-permission flag. A read is refused while a single-shot result is still due. A free-running channel is always readable and shows zero until its first sample lands. The current sample also goes out with a one-cycle valid pulse for the overcurrent comparison logic. A range-select bit is stored and passed on to the analog divider.

Top module: `adc_conv_seq`

## Requirements
- R1: After reset the command bits are 0, no start strobe is issued, both readback registers read 0, `read_ok_o` is 1 and `vrange_o` is 0.
- R2: Command bit 0 set makes the block convert voltage (`adc_sel_o`=0) over and over, and `v_result_o` always holds the latest voltage sample. Clearing the bit stops new passes once the pass in flight ends.
- R3: Command bit 2 set makes the block convert current (`adc_sel_o`=1) over and over, and `i_result_o` always holds the latest current sample.
- R4: Command bit 1 (voltage) and bit 3 (current) each request exactly one conversion of their channel. The bit clears itself when the pass is launched, so no further strobe follows.
- R5: A pass covering both channels issues the voltage strobe before the current strobe. `v_result_o` and `i_result_o` update on the same clock edge.
- R6: Writing a single-shot bit drops `read_ok_o` to 0 on the write edge. It rises back to 1 on the edge where that channel's result is committed.
- R7: Setting a free-running bit leaves `read_ok_o` at 1, and the readback register stays 0 until the first sample is committed.
- R8: `conv_pin_i` passes through a two-flop synchroniser. A rising edge launches one pass over the channel mask from the last command write. A channel is in the mask when its bit 0/1 (voltage) or bit 2/3 (current) was 1. A pin held high launches only one pass.
- R9: A pin rising edge while the stored channel mask is empty starts no conversion.
- R10: Command bit 4 is stored and driven on `vrange_o`, and writing it alone starts no conversion.
- R11: `i_valid_o` pulses for one cycle on each edge where a new current sample is committed to `i_result_o`.
- R12: `adc_start_o` is high for exactly one cycle per conversion, and `adc_sel_o` changes only on a strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command register write enable |
| cmd_wdata_i | input | 5 | Command bits: 0 voltage free-run, 1 voltage single, 2 current free-run, 3 current single, 4 range select |
| conv_pin_i | input | 1 | Asynchronous convert request pin |
| adc_sel_o | output | 1 | Converter channel: 0 voltage, 1 current |
| adc_start_o | output | 1 | One-cycle conversion start strobe |
| adc_done_i | input | 1 | Converter done pulse |
| adc_data_i | input | 12 | Converter sample, valid with done |
| vrange_o | output | 1 | Stored voltage range select |
| read_ok_o | output | 1 | 1 when a bus read may be acknowledged |
| v_result_o | output | 12 | Voltage readback register |
| i_result_o | output | 12 | Current readback register |
| i_valid_o | output | 1 | One-cycle pulse on each new current sample |

## Verification
The bench targets the two read-gating modes. A design that gated free-running reads would refuse reads it must acknowledge. A design that left single-shot reads open would return stale data. In a two-channel pass the bench checks the strobe order and that both registers land together. Reversed order, or voltage committed early, shows up as a wrong select log or a change on different edges. A held convert pin must give exactly one pass, and an empty mask none. A level-triggered or unsynchronised pin would loop or misfire. The bench also counts strobes after each single-shot request. A bit that never self-clears shows up as extra conversions.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int unsigned CH_V = 0;
  localparam int unsigned CH_I = 1;
  localparam int unsigned N_CH = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_VCONV = 2'd1,
    ST_ICONV = 2'd2
  } seq_state_e;
endpackage

// File: rtl/adc_pin_sync.sv
module adc_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/adc_cmd_regs.sv
module adc_cmd_regs
  import adc_seq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [4:0]      wdata_i,
  input  logic            launch_i,
  input  logic            commit_i,
  input  logic [N_CH-1:0] commit_once_i,
  output logic [N_CH-1:0] cont_o,
  output logic [N_CH-1:0] once_o,
  output logic [N_CH-1:0] mask_o,
  output logic            vrange_o,
  output logic            read_ok_o
);
  logic [N_CH-1:0] cont_q, once_q, mask_q, wait_q;
  logic            vrange_q;
  logic [N_CH-1:0] wr_cont, wr_once, wait_clr;

  assign wr_cont  = {wdata_i[2], wdata_i[0]};
  assign wr_once  = {wdata_i[3], wdata_i[1]};
  assign wait_clr = commit_i ? commit_once_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cont_q   <= '0;
      once_q   <= '0;
      mask_q   <= '0;
      wait_q   <= '0;
      vrange_q <= 1'b0;
    end else begin
      wait_q <= (wait_q & ~wait_clr) | (we_i ? wr_once : '0);
      if (we_i) begin
        cont_q   <= wr_cont;
        once_q   <= wr_once;
        mask_q   <= wr_cont | wr_once;
        vrange_q <= wdata_i[4];
      end else if (launch_i) begin
        once_q <= '0;
      end
    end
  end

  assign cont_o    = cont_q;
  assign once_o    = once_q;
  assign mask_o    = mask_q;
  assign vrange_o  = vrange_q;
  assign read_ok_o = ~|wait_q;
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int unsigned DW = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            hold_i,
  input  logic [N_CH-1:0] cont_i,
  input  logic [N_CH-1:0] once_i,
  input  logic [N_CH-1:0] mask_i,
  input  logic            pin_rise_i,
  input  logic            done_i,
  input  logic [DW-1:0]   data_i,
  output logic            start_o,
  output logic            sel_o,
  output logic            launch_o,
  output logic            commit_o,
  output logic [N_CH-1:0] commit_once_o,
  output logic [DW-1:0]   v_res_o,
  output logic [DW-1:0]   i_res_o,
  output logic            i_valid_o
);
  seq_state_e      state_q;
  logic [N_CH-1:0] do_q, once_set_q, pin_req_q, want, pin_new;
  logic [DW-1:0]   v_tmp_q, v_res_q, i_res_q;
  logic            start_q, sel_q, ival_q;

  assign pin_new  = pin_rise_i ? mask_i : '0;
  assign want     = cont_i | once_i | pin_req_q;
  assign launch_o = (state_q == ST_IDLE) && !hold_i && (|want);
  assign commit_o = done_i && (((state_q == ST_VCONV) && !do_q[CH_I]) ||
                               (state_q == ST_ICONV));
  assign commit_once_o = once_set_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      do_q       <= '0;
      once_set_q <= '0;
      pin_req_q  <= '0;
      v_tmp_q    <= '0;
      v_res_q    <= '0;
      i_res_q    <= '0;
      start_q    <= 1'b0;
      sel_q      <= 1'b0;
      ival_q     <= 1'b0;
    end else begin
      start_q   <= 1'b0;
      ival_q    <= 1'b0;
      pin_req_q <= (launch_o ? '0 : pin_req_q) | pin_new;
      unique case (state_q)
        ST_IDLE: if (launch_o) begin
          do_q       <= want;
          once_set_q <= once_i;
          start_q    <= 1'b1;
          if (want[CH_V]) begin
            sel_q   <= 1'b0;
            state_q <= ST_VCONV;
          end else begin
            sel_q   <= 1'b1;
            state_q <= ST_ICONV;
          end
        end
        ST_VCONV: if (done_i) begin
          v_tmp_q <= data_i;
          if (do_q[CH_I]) begin
            sel_q   <= 1'b1;
            start_q <= 1'b1;
            state_q <= ST_ICONV;
          end else begin
            v_res_q <= data_i;
            state_q <= ST_IDLE;
          end
        end
        ST_ICONV: if (done_i) begin
          i_res_q <= data_i;
          ival_q  <= 1'b1;
          if (do_q[CH_V]) v_res_q <= v_tmp_q;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign start_o   = start_q;
  assign sel_o     = sel_q;
  assign v_res_o   = v_res_q;
  assign i_res_o   = i_res_q;
  assign i_valid_o = ival_q;
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned DW          = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_we_i,
  input  logic [4:0]    cmd_wdata_i,
  input  logic          conv_pin_i,
  output logic          adc_sel_o,
  output logic          adc_start_o,
  input  logic          adc_done_i,
  input  logic [DW-1:0] adc_data_i,
  output logic          vrange_o,
  output logic          read_ok_o,
  output logic [DW-1:0] v_result_o,
  output logic [DW-1:0] i_result_o,
  output logic          i_valid_o
);
  logic            pin_rise, launch, commit;
  logic [N_CH-1:0] cont, once, mask, commit_once;

  adc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (conv_pin_i),
    .rise_o (pin_rise)
  );

  adc_cmd_regs u_cmd (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .we_i          (cmd_we_i),
    .wdata_i       (cmd_wdata_i),
    .launch_i      (launch),
    .commit_i      (commit),
    .commit_once_i (commit_once),
    .cont_o        (cont),
    .once_o        (once),
    .mask_o        (mask),
    .vrange_o      (vrange_o),
    .read_ok_o     (read_ok_o)
  );

  adc_seq_fsm #(.DW(DW)) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .hold_i        (cmd_we_i),
    .cont_i        (cont),
    .once_i        (once),
    .mask_i        (mask),
    .pin_rise_i    (pin_rise),
    .done_i        (adc_done_i),
    .data_i        (adc_data_i),
    .start_o       (adc_start_o),
    .sel_o         (adc_sel_o),
    .launch_o      (launch),
    .commit_o      (commit),
    .commit_once_o (commit_once),
    .v_res_o       (v_result_o),
    .i_res_o       (i_result_o),
    .i_valid_o     (i_valid_o)
  );
endmodule

// File: rtl/adc_conv_seq_chk.sv
module adc_conv_seq_chk #(
  parameter int unsigned DW = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cmd_we_i,
  input logic [4:0]    cmd_wdata_i,
  input logic          adc_sel_o,
  input logic          adc_start_o,
  input logic          adc_done_i,
  input logic          vrange_o,
  input logic          read_ok_o,
  input logic [DW-1:0] v_result_o,
  input logic [DW-1:0] i_result_o,
  input logic          i_valid_o
);
  logic last_sel_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          last_sel_q <= 1'b0;
    else if (adc_start_o) last_sel_q <= adc_sel_o;
  end

  p_strobe_single_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |=> !adc_start_o);

  p_sel_only_on_strobe_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adc_start_o |-> $stable(adc_sel_o));

  p_current_last_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    i_valid_o |-> last_sel_q);

  p_ready_on_commit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(read_ok_o) |-> $past(adc_done_i));

  p_vrange_store_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_i |=> (vrange_o == $past(cmd_wdata_i[4])));

  p_vres_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(adc_done_i) |-> $stable(v_result_o));

  p_ires_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(adc_done_i) |-> ($stable(i_result_o) && !i_valid_o));
endmodule

bind adc_conv_seq adc_conv_seq_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_we_i    (cmd_we_i),
  .cmd_wdata_i (cmd_wdata_i),
  .adc_sel_o   (adc_sel_o),
  .adc_start_o (adc_start_o),
  .adc_done_i  (adc_done_i),
  .vrange_o    (vrange_o),
  .read_ok_o   (read_ok_o),
  .v_result_o  (v_result_o),
  .i_result_o  (i_result_o),
  .i_valid_o   (i_valid_o)
);

// File: tb/adc_conv_seq_tb_top.sv
module adc_conv_seq_tb_top;
  localparam int DW  = 12;
  localparam int LAT = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_we = 1'b0;
  logic [4:0]    cmd_wdata = '0;
  logic          conv_pin = 1'b0;
  logic          adc_sel, adc_start, vrange, read_ok, i_valid;
  logic          adc_done = 1'b0;
  logic [DW-1:0] adc_data = '0;
  logic [DW-1:0] v_res, i_res;

  int n_tests = 0, n_fail = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  adc_conv_seq dut_i (
    .clk_i (clk), .rst_ni (rst_n), .cmd_we_i (cmd_we), .cmd_wdata_i (cmd_wdata),
    .conv_pin_i (conv_pin), .adc_sel_o (adc_sel), .adc_start_o (adc_start),
    .adc_done_i (adc_done), .adc_data_i (adc_data), .vrange_o (vrange),
    .read_ok_o (read_ok), .v_result_o (v_res), .i_result_o (i_res),
    .i_valid_o (i_valid)
  );

  // converter model
  int cnt = 0, seq = 0;
  logic cur_sel = 1'b0;
  logic [DW-1:0] last_v = '0, last_i = '0;
  always @(posedge clk) begin
    adc_done <= 1'b0;
    if (adc_start) begin
      cnt <= LAT;
      cur_sel <= adc_sel;
    end else if (cnt > 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) begin
        adc_done <= 1'b1;
        seq <= seq + 1;
        if (cur_sel) begin
          adc_data <= DW'(12'h800 + seq); last_i <= DW'(12'h800 + seq);
        end else begin
          adc_data <= DW'(12'h100 + seq); last_v <= DW'(12'h100 + seq);
        end
      end
    end
  end

  // monitor, sampled on the falling edge
  int starts = 0, v_upd = 0, i_upd = 0, ival_cnt = 0, long_strobe = 0, sel_glitch = 0;
  int cyc = 0, v_upd_cyc = -1, i_upd_cyc = -1;
  bit sel_log[$];
  logic prev_start = 1'b0, prev_sel = 1'b0;
  logic [DW-1:0] prev_v = '0, prev_i = '0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (adc_start) begin starts++; sel_log.push_back(adc_sel); end
      if (adc_start && prev_start) long_strobe++;
      if (!adc_start && adc_sel != prev_sel) sel_glitch++;
      if (v_res != prev_v) begin v_upd++; v_upd_cyc = cyc; end
      if (i_res != prev_i) begin i_upd++; i_upd_cyc = cyc; end
      if (i_valid) ival_cnt++;
    end
    prev_start = adc_start; prev_sel = adc_sel; prev_v = v_res; prev_i = i_res;
  end

  task automatic check(input string req, input bit ok, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] d);
    @(negedge clk); cmd_we = 1'b1; cmd_wdata = d;
    @(negedge clk); cmd_we = 1'b0;
  endtask

  task automatic wait_ready();
    for (int k = 0; k < 200 && !read_ok; k++) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int snap, u0, iv0;
    idle(4); rst_n = 1'b1; idle(10);
    // R1
    check("R1 read_ok", read_ok == 1, read_ok, 1);
    check("R1 results", v_res == 0 && i_res == 0, {v_res, i_res}, 0);
    check("R1 vrange", vrange == 0, vrange, 0);
    check("R1 no start", starts == 0, starts, 0);

    // R7 and R2: voltage free-run
    wr(5'b00001);
    for (int k = 0; k < 3; k++) begin
      check("R7 readable", read_ok == 1, read_ok, 1);
      check("R7 zero before first", v_res == 0, v_res, 0);
      @(negedge clk);
    end
    for (int k = 0; k < 200 && v_upd < 3; k++) @(negedge clk);
    check("R2 repeated voltage", v_upd >= 3, v_upd, 3);
    check("R2 latest sample", v_res == last_v, v_res, last_v);
    check("R2 channel", i_upd == 0, i_upd, 0);
    wr(5'b00000); idle(20); snap = starts; idle(30);
    check("R2 stop", starts == snap, starts, snap);

    // R3 and R11: current free-run
    u0 = i_upd; iv0 = ival_cnt;
    wr(5'b00100);
    for (int k = 0; k < 200 && i_upd < u0 + 3; k++) @(negedge clk);
    check("R3 repeated current", i_upd >= u0 + 3, i_upd, u0 + 3);
    check("R3 latest sample", i_res == last_i, i_res, last_i);
    check("R11 valid per sample", ival_cnt - iv0 == i_upd - u0, ival_cnt - iv0, i_upd - u0);
    wr(5'b00000); idle(30);

    // R4 and R6: voltage single
    snap = starts;
    wr(5'b00010);
    check("R6 refused while due", read_ok == 0, read_ok, 0);
    wait_ready();
    check("R6 ready after result", read_ok == 1, read_ok, 1);
    check("R4 voltage single value", v_res == last_v, v_res, last_v);
    idle(30);
    check("R4 one strobe", starts - snap == 1, starts - snap, 1);

    // R4 current single
    snap = starts; iv0 = ival_cnt;
    wr(5'b01000);
    check("R6 refused current", read_ok == 0, read_ok, 0);
    wait_ready();
    check("R4 current single value", i_res == last_i, i_res, last_i);
    idle(30);
    check("R4 one current strobe", starts - snap == 1, starts - snap, 1);
    check("R11 single pulse", ival_cnt - iv0 == 1, ival_cnt - iv0, 1);

    // R5: both channels in one pass
    sel_log.delete();
    wr(5'b01010);
    wait_ready(); idle(2);
    check("R5 two strobes", sel_log.size() == 2, sel_log.size(), 2);
    if (sel_log.size() == 2)
      check("R5 voltage first", sel_log[0] == 0 && sel_log[1] == 1, {sel_log[0], sel_log[1]}, 2'b01);
    check("R5 same edge", v_upd_cyc == i_upd_cyc, v_upd_cyc, i_upd_cyc);
    check("R5 values", v_res == last_v && i_res == last_i, v_res, last_v);
    idle(20);

    // R8: pin held high gives one pass over the stored mask
    sel_log.delete(); snap = starts;
    conv_pin = 1'b1; idle(60);
    check("R8 one pass", starts - snap == 2, starts - snap, 2);
    if (sel_log.size() == 2)
      check("R8 order", sel_log[0] == 0 && sel_log[1] == 1, {sel_log[0], sel_log[1]}, 2'b01);
    check("R8 readable", read_ok == 1, read_ok, 1);
    conv_pin = 1'b0; idle(10);

    // R9: empty mask
    wr(5'b00000); snap = starts;
    conv_pin = 1'b1; idle(30); conv_pin = 1'b0; idle(20);
    check("R9 no pass", starts == snap, starts, snap);

    // R10
    wr(5'b10000);
    check("R10 vrange set", vrange == 1, vrange, 1);
    idle(20);
    check("R10 no pass", starts == snap, starts, snap);
    wr(5'b00000);
    check("R10 vrange clear", vrange == 0, vrange, 0);

    // R12
    check("R12 strobe width", long_strobe == 0, long_strobe, 0);
    check("R12 sel stable", sel_glitch == 0, sel_glitch, 0);

    done_flag = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule